// File: doc/BRIEF.md
# Elastic Receive FIFO with Programmable Start Margin

This block moves data from a link receive clock domain into an internal clock domain. The link side delivers one byte on every edge of its receive clock. The block packs each group of four bytes into a 32-bit word and writes it into an eight-entry circular store. The internal side takes words out of the store one at a time. It does so on any internal clock cycle where the unload enable is high. Reads in the internal domain must trail writes in the link domain by a safe distance. That gives a written entry time to settle before it is read.

The distance is set when the link leaves reset. The load pointer starts at entry 0. The unload pointer starts behind it by a programmed amount, taken modulo 8. The margin configuration field holds twice that amount. A sync indication from the link enters the internal domain through a four-stage synchronizer and raises a sticky link-up flag. The block has two modes. In synchronous mode both pointers move as soon as the block leaves reset. In asynchronous mode loading waits until the sync indication has been seen, and unloading waits for link-up. A sticky overrun flag marks any write that lands on the entry the unload pointer is about to read.

Top module: `elastic_rx_fifo`

## Requirements
- R1: While reset is applied and after it is released, `link_up`, `overrun` and `rd_data` are 0 until an event below changes them.
- R2: In a receive clock cycle where `rx_en` is high at the rising edge, the byte present at that rising edge and the byte present at the following falling edge are captured. Two such cycles form one word. The first byte goes in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R3: After reset the load pointer is at entry 0. It advances by one for each completed word and wraps from 7 to 0, so a ninth word overwrites entry 0.
- R4: After reset the unload pointer starts at (0 - margin_cfg[3:1]) mod 8; margin_cfg[0] has no effect.
- R5: When an unload is allowed and `unload_en` is high at a rising edge of `clk`, `rd_data` takes the entry at the unload pointer at that edge and the pointer advances by one modulo 8. Otherwise `rd_data` holds its value.
- R6: `link_up` rises at the fifth rising edge of `clk` after `rx_sync` goes high. It then stays high until reset, even if `rx_sync` falls.
- R7: With `sync_mode` = 1, loading and unloading run from reset release regardless of `rx_sync` and `link_up`.
- R8: With `sync_mode` = 0, `rx_en` is ignored until `rx_sync` has been seen high at a rising edge of `rx_clk`. `unload_en` is ignored until `link_up` is high.
- R9: `overrun` is set when a word is written to the entry the unload pointer currently addresses, including the first write when the offset is 0. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; unload side |
| rst_n | input | 1 | Asynchronous active-low link reset, released synchronously in each domain |
| rx_clk | input | 1 | Link receive clock; bytes are taken on both edges |
| rx_byte | input | 8 | Received byte |
| rx_en | input | 1 | Capture enable for the bytes of the current receive clock cycle, sampled at the rising edge |
| rx_sync | input | 1 | Sync indication from the link |
| sync_mode | input | 1 | 1 = synchronous mode, 0 = asynchronous mode |
| margin_cfg | input | 4 | Twice the start offset of the unload pointer behind the load pointer |
| unload_en | input | 1 | Per-cycle unload enable, internal domain |
| rd_data | output | 32 | Last word unloaded |
| link_up | output | 1 | Sticky flag: synchronized sync indication has arrived |
| overrun | output | 1 | Sticky flag: a write reached the entry about to be read (receive domain) |

## Verification
A wrong start offset or a pointer that steps wrongly cannot be seen at once. It shows on the first unload as a word from the wrong entry. The bench therefore fills every entry with a distinct value before it tests any offset. A word packed in the wrong byte order shows up in `rd_data` one internal cycle after it is unloaded. A wrong overrun comparison shows on `overrun` within half a receive clock of the write that caused it. A synchronizer with the wrong depth moves `link_up` by one or more internal edges, so the bench checks the edge just before and the edge at which the flag must rise. In asynchronous mode a broken gate shows up in two ways. A word loaded too early shifts the entry later words land in. An unload taken too early changes both `rd_data` and the words read afterwards.

// File: rtl/erf_pkg.sv
package erf_pkg;
  localparam int DEPTH       = 8;
  localparam int PTR_W       = $clog2(DEPTH);
  localparam int BYTE_W      = 8;
  localparam int BYTES       = 4;
  localparam int DATA_W      = BYTE_W * BYTES;
  localparam int CFG_W       = PTR_W + 1;
  localparam int SYNC_STAGES = 4;
  localparam int RST_STAGES  = 2;
  localparam int PTR_STAGES  = 2;

  typedef logic [PTR_W-1:0] ptr_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/erf_sync.sv
module erf_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/erf_load.sv
module erf_load
  import erf_pkg::*;
#(
  parameter int N_ENTRY = DEPTH,
  parameter int BW      = BYTE_W,
  parameter int DW      = DATA_W
) (
  input  logic                       rx_clk,
  input  logic                       rx_run_n,
  input  logic [BW-1:0]              rx_byte,
  input  logic                       rx_en,
  input  logic                       rx_sync,
  input  logic                       sync_mode,
  input  ptr_t                       uptr_gray,
  output logic [N_ENTRY-1:0][DW-1:0] mem_q,
  output logic                       overrun
);
  localparam int PAIR_W = 2 * BW;
  localparam int PAIRS  = DW / PAIR_W;
  localparam int CNT_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int PART_W = DW - PAIR_W;

  // rising-edge side: arming and first byte of each cycle
  logic          armed_q, armed_d;
  logic          pos_vld_q, pos_vld_d;
  logic [BW-1:0] pos_q;
  logic          load_go;

  assign load_go = sync_mode | armed_q;

  always_comb begin
    armed_d   = armed_q | rx_sync;
    pos_vld_d = rx_en & load_go;
  end

  always_ff @(posedge rx_clk or negedge rx_run_n) begin
    if (!rx_run_n) begin
      armed_q   <= 1'b0;
      pos_vld_q <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      pos_vld_q <= pos_vld_d;
    end
  end

  always_ff @(posedge rx_clk) begin
    if (rx_en) begin
      pos_q <= rx_byte;
    end
  end

  // unload pointer brought into the receive domain
  ptr_t ugray_rx, uptr_rx;

  erf_sync #(.WIDTH(PTR_W), .STAGES(PTR_STAGES)) u_uptr_sync (
    .clk   (rx_clk),
    .rst_n (rx_run_n),
    .d     (uptr_gray),
    .q     (ugray_rx)
  );

  assign uptr_rx = gray2bin(ugray_rx);

  // falling-edge side: pair completion, word assembly, store write
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  ptr_t              wptr_q, wptr_d;
  logic              ov_q, ov_d;
  logic [PART_W-1:0] part_q;
  logic [PAIR_W-1:0] pair;
  logic [DW-1:0]     word;
  logic              last;

  always_comb begin
    pair   = {rx_byte, pos_q};
    word   = {pair, part_q};
    last   = pos_vld_q && (cnt_q == CNT_W'(PAIRS - 1));
    cnt_d  = cnt_q;
    wptr_d = wptr_q;
    ov_d   = ov_q;
    if (pos_vld_q) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
    if (last) begin
      wptr_d = wptr_q + 1'b1;
      ov_d   = ov_q | (wptr_q == uptr_rx);
    end
  end

  always_ff @(negedge rx_clk or negedge rx_run_n) begin
    if (!rx_run_n) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wptr_q <= wptr_d;
      ov_q   <= ov_d;
    end
  end

  always_ff @(negedge rx_clk) begin
    if (pos_vld_q) begin
      part_q <= word[DW-1:PAIR_W];
    end
  end

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_entry
    always_ff @(negedge rx_clk) begin
      if (last && (wptr_q == ptr_t'(e))) begin
        mem_q[e] <= word;
      end
    end
  end

  assign overrun = ov_q;

  // R3: load pointer moves by at most one entry per falling edge
  a_r3_ptr_step: assert property (@(negedge rx_clk) disable iff (!rx_run_n)
    (wptr_q == $past(wptr_q)) || (wptr_q == ptr_t'($past(wptr_q) + 1'b1)));

  // R9: overrun never clears without reset
  a_r9_overrun_sticky: assert property (@(negedge rx_clk) disable iff (!rx_run_n)
    $past(ov_q) |-> ov_q);

  // R8: no store write in asynchronous mode before arming
  a_r8_load_gated: assert property (@(negedge rx_clk) disable iff (!rx_run_n)
    (!sync_mode && !armed_q) |=> $stable(wptr_q));
endmodule

// File: rtl/erf_unload.sv
module erf_unload
  import erf_pkg::*;
#(
  parameter int N_ENTRY = DEPTH,
  parameter int DW      = DATA_W,
  parameter int CW      = CFG_W
) (
  input  logic                       clk,
  input  logic                       run_n,
  input  logic [CW-1:0]              margin_cfg,
  input  logic                       sync_mode,
  input  logic                       sync_s,
  input  logic                       unload_en,
  input  logic [N_ENTRY-1:0][DW-1:0] mem_q,
  output logic [DW-1:0]              rd_data,
  output logic                       link_up,
  output ptr_t                       uptr_gray
);
  logic          init_q, init_d;
  logic          link_q, link_d;
  ptr_t          uptr_q, uptr_d;
  ptr_t          gray_q, gray_d;
  logic [DW-1:0] rd_q, rd_d;
  ptr_t          neg_off;
  logic          fire;

  // field holds twice the offset; halve, then negate modulo the depth
  assign neg_off = ptr_t'(0) - ptr_t'(margin_cfg >> 1);
  assign fire    = unload_en & (sync_mode | link_q) & ~init_q;

  always_comb begin
    init_d = 1'b0;
    link_d = link_q | sync_s;
    uptr_d = uptr_q;
    rd_d   = rd_q;
    if (init_q) begin
      uptr_d = neg_off;
    end else if (fire) begin
      uptr_d = uptr_q + 1'b1;
      rd_d   = mem_q[uptr_q];
    end
    gray_d = bin2gray(uptr_d);
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      init_q <= 1'b1;
      link_q <= 1'b0;
      uptr_q <= '0;
      gray_q <= '0;
      rd_q   <= '0;
    end else begin
      init_q <= init_d;
      link_q <= link_d;
      uptr_q <= uptr_d;
      gray_q <= gray_d;
      rd_q   <= rd_d;
    end
  end

  assign rd_data   = rd_q;
  assign link_up   = link_q;
  assign uptr_gray = gray_q;

  // R4: unload pointer placed at the programmed distance behind entry 0
  a_r4_init_offset: assert property (@(posedge clk) disable iff (!run_n)
    $fell(init_q) |-> (uptr_q == neg_off));

  // R5: pointer holds on cycles without an unload
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!run_n)
    (!$past(init_q) && !$past(fire)) |-> $stable(uptr_q));

  // R6: link-up is sticky
  a_r6_link_sticky: assert property (@(posedge clk) disable iff (!run_n)
    $past(link_q) |-> link_q);

  // R8: output word frozen before link-up in asynchronous mode
  a_r8_unload_gated: assert property (@(posedge clk) disable iff (!run_n)
    (!sync_mode && !link_q) |=> $stable(rd_q));
endmodule

// File: rtl/elastic_rx_fifo.sv
module elastic_rx_fifo
  import erf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_clk,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_en,
  input  logic              rx_sync,
  input  logic              sync_mode,
  input  logic [CFG_W-1:0]  margin_cfg,
  input  logic              unload_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              link_up,
  output logic              overrun
);
  logic                        run_n;
  logic                        rx_run_n;
  logic                        sync_s;
  ptr_t                        uptr_gray;
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  erf_sync #(.WIDTH(1), .STAGES(RST_STAGES)) u_rst_int (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (run_n)
  );

  erf_sync #(.WIDTH(1), .STAGES(RST_STAGES)) u_rst_rx (
    .clk   (rx_clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rx_run_n)
  );

  erf_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_chain (
    .clk   (clk),
    .rst_n (run_n),
    .d     (rx_sync),
    .q     (sync_s)
  );

  erf_load u_load (
    .rx_clk    (rx_clk),
    .rx_run_n  (rx_run_n),
    .rx_byte   (rx_byte),
    .rx_en     (rx_en),
    .rx_sync   (rx_sync),
    .sync_mode (sync_mode),
    .uptr_gray (uptr_gray),
    .mem_q     (mem_q),
    .overrun   (overrun)
  );

  erf_unload u_unload (
    .clk        (clk),
    .run_n      (run_n),
    .margin_cfg (margin_cfg),
    .sync_mode  (sync_mode),
    .sync_s     (sync_s),
    .unload_en  (unload_en),
    .mem_q      (mem_q),
    .rd_data    (rd_data),
    .link_up    (link_up),
    .uptr_gray  (uptr_gray)
  );
endmodule

// File: tb/sim_elastic_rx_fifo.sv
module sim_elastic_rx_fifo;
  logic        clk, rst_n, rx_clk;
  logic [7:0]  rx_byte;
  logic        rx_en, rx_sync, sync_mode, unload_en;
  logic [3:0]  margin_cfg;
  logic [31:0] rd_data;
  logic        link_up, overrun;

  int tests = 0;
  int fails = 0;

  elastic_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_byte(rx_byte),
    .rx_en(rx_en), .rx_sync(rx_sync), .sync_mode(sync_mode),
    .margin_cfg(margin_cfg), .unload_en(unload_en), .rd_data(rd_data),
    .link_up(link_up), .overrun(overrun)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    rx_clk = 1'b0;
    #7;
    forever #20 rx_clk = ~rx_clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode, input logic [3:0] cfg);
    @(negedge clk);
    rst_n = 1'b0;
    sync_mode = mode;
    margin_cfg = cfg;
    rx_en = 1'b0;
    rx_sync = 1'b0;
    unload_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int h = 0; h < 2; h++) begin
      @(negedge rx_clk);
      #5 rx_en = 1'b1;
      rx_byte = w[16*h +: 8];
      @(posedge rx_clk);
      #5 rx_byte = w[16*h+8 +: 8];
    end
  endtask

  task automatic rx_idle();
    @(negedge rx_clk);
    #5 rx_en = 1'b0;
  endtask

  task automatic unload_one();
    @(negedge clk);
    #1 unload_en = 1'b1;
    @(negedge clk);
    #1 unload_en = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    #45;
    check("R1 link_up in reset", {31'd0, link_up}, 32'd0);
    check("R1 overrun in reset", {31'd0, overrun}, 32'd0);
    do_reset(1'b1, 4'd4);
    check("R1 rd_data after reset", rd_data, 32'd0);
  endtask

  // sync mode, offset 2: unload pointer at 6, writes to 0..5 are safe
  task automatic t_fill_overrun();
    for (int k = 0; k < 6; k++) send_word(32'hA000_0000 + k);
    rx_idle();
    check("R9 no overrun below margin", {31'd0, overrun}, 32'd0);
    send_word(32'hA000_0006);
    rx_idle();
    check("R9 overrun at unload entry", {31'd0, overrun}, 32'd1);
    send_word(32'hA000_0007);
    rx_idle();
    check("R9 overrun sticky", {31'd0, overrun}, 32'd1);
  endtask

  // sync mode, cfg 6 -> offset 3 -> start at entry 5
  task automatic t_margin_read();
    do_reset(1'b1, 4'd6);
    check("R9 overrun cleared by reset", {31'd0, overrun}, 32'd0);
    unload_one();
    check("R4 first read from entry 5", rd_data, 32'hA000_0005);
    unload_one();
    check("R5 second read from entry 6", rd_data, 32'hA000_0006);
    check("R7 sync mode runs without link_up", {31'd0, link_up}, 32'd0);
  endtask

  // sync mode, offset 0: first write overruns; ninth word wraps to entry 0
  task automatic t_wrap_order();
    do_reset(1'b1, 4'd0);
    send_word(32'hC000_0000);
    rx_idle();
    check("R9 overrun with zero offset", {31'd0, overrun}, 32'd1);
    for (int k = 1; k < 8; k++) send_word(32'hC000_0000 + k);
    send_word(32'h4433_2211);
    rx_idle();
    unload_one();
    check("R3 R2 wrapped word in entry 0, byte order", rd_data, 32'h4433_2211);
    unload_one();
    check("R3 entry 1 read next", rd_data, 32'hC000_0001);
  endtask

  // async mode, cfg 5 -> offset 2 (bit 0 ignored) -> start at entry 6
  task automatic t_async_start();
    do_reset(1'b0, 4'd5);
    send_word(32'hD000_0000);
    rx_idle();
    unload_one();
    check("R8 unload ignored before link_up", rd_data, 32'd0);
    @(negedge clk);
    #1 rx_sync = 1'b1;
    repeat (4) @(posedge clk);
    #5 check("R6 link_up low at 4th edge", {31'd0, link_up}, 32'd0);
    @(posedge clk);
    #5 check("R6 link_up high at 5th edge", {31'd0, link_up}, 32'd1);
    repeat (4) @(negedge clk);
    send_word(32'hD000_0001);
    rx_idle();
    unload_one();
    check("R4 R8 start entry 6 unmoved, cfg bit0 ignored", rd_data, 32'hC000_0006);
    unload_one();
    check("R5 entry 7", rd_data, 32'hC000_0007);
    unload_one();
    check("R8 early word dropped, later word at entry 0", rd_data, 32'hD000_0001);
    @(negedge clk);
    rx_sync = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 link_up sticky", {31'd0, link_up}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    rx_byte = 8'h00;
    rx_en = 1'b0;
    rx_sync = 1'b0;
    sync_mode = 1'b1;
    margin_cfg = 4'd4;
    unload_en = 1'b0;
    t_reset_state();
    t_fill_overrun();
    t_margin_read();
    t_wrap_order();
    t_async_start();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule